// File: doc/BRIEF.md
# Double-Press Motor Enable Controller

This block is a small synchronous state machine that drives one motor-enable line from a debounced run/stop button and an emergency-stop input. A single press does not start the motor. The first press arms the controller and opens a timing window. A second press that arrives inside that window switches the motor on. If the window closes before a second press, the controller drops back to idle.

While the motor runs, one more press switches it off. The motor also switches off by itself once a maximum on-time has passed. The emergency input overrides everything else: it forces the output low and returns the machine to idle. One shared cycle counter measures both the arming window and the on-time. Both limits are parameters in clock cycles, which lets a bench run with short windows.

Top module: `dbl_press_motor_ctrl`

## Requirements
- R1: After a synchronous reset, `motor_on` is 0 and the controller is idle, so one later press only arms it.
- R2: A press is a 0-to-1 transition of `run_btn` between two consecutive clock samples. Holding the button high for many cycles counts as one press.
- R3: A press sampled while idle arms the controller and leaves `motor_on` at 0.
- R4: If the first press is sampled at edge k and a second press is sampled at edge k+j, with 1 <= j <= WINDOW_CYC-1, then `motor_on` reads 1 just after edge k+j.
- R5: If no press is sampled at edges k+1 to k+WINDOW_CYC-1, the controller returns to idle at edge k+WINDOW_CYC. A press sampled at that same edge is ignored, and the next press arms the controller again.
- R6: A press sampled while the motor runs sets `motor_on` to 0 just after that edge.
- R7: Once started, `motor_on` stays at 1 for at most ONTIME_CYC consecutive cycles. With no press and no emergency, it stays high for exactly ONTIME_CYC cycles.
- R8: When `estop` is 1 at an edge, `motor_on` is 0 and the controller is idle after that edge. This holds whatever `run_btn` does, including a press in the same cycle.
- R9: `motor_on` comes from a register and depends only on the machine state, never directly on the current inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run_btn | input | 1 | Debounced run/stop button level, 1 = pressed |
| estop | input | 1 | Emergency stop, active high |
| motor_on | output | 1 | Motor enable, registered |

## Verification
The hardest cases to reach from the ports are the edges of the arming window. A second press one cycle before expiry must start the motor. A second press exactly at expiry must be dropped, and only the press after that may re-arm. The bench sets the window to 20 cycles and places presses at exact offsets of 19 and 20 edges from the first press. It also holds the button high for many cycles to show that a long press counts once. Emergency is driven in the same cycle as a press, both while idle and while armed, to show that emergency wins.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } dpm_state_e;
endpackage

// File: rtl/dpm_press_detect.sv
module dpm_press_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic press
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign press = level & ~level_q;

  // R2
  single_press_chk: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);
endmodule

// File: rtl/dpm_cycle_timer.sv
module dpm_cycle_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          expired
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else            count <= count + 1'b1;
  end

  assign expired = (count == limit - 1'b1);
endmodule

// File: rtl/dpm_fsm.sv
module dpm_fsm
  import dpm_pkg::*;
#(
  parameter int WINDOW_CYC = 20,
  parameter int ONTIME_CYC = 16,
  parameter int CW         = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          press,
  input  logic          estop,
  input  logic          expired,
  output dpm_state_e    state,
  output logic [CW-1:0] limit,
  output logic          clr,
  output logic          motor_on
);
  localparam logic [CW-1:0] WIN_L = CW'(WINDOW_CYC);
  localparam logic [CW-1:0] ON_L  = CW'(ONTIME_CYC);

  dpm_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (press) nxt = ST_ARMED;
      ST_ARMED: begin
        if (expired)    nxt = ST_IDLE;
        else if (press) nxt = ST_RUN;
      end
      ST_RUN:   if (press || expired) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    if (estop) nxt = ST_IDLE;
  end

  assign limit = (state == ST_RUN) ? ON_L : WIN_L;
  assign clr   = (nxt != state) || (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      motor_on <= 1'b0;
    end else begin
      state    <= nxt;
      motor_on <= (nxt == ST_RUN);
    end
  end

  // R4
  start_path_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(motor_on) |-> ($past(state) == ST_ARMED && $past(press)));
  // R6
  run_press_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && press) |=> !motor_on);
  // R3
  idle_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |=> !motor_on);
endmodule

// File: rtl/dbl_press_motor_ctrl.sv
module dbl_press_motor_ctrl
  import dpm_pkg::*;
#(
  parameter int WINDOW_CYC = 1500000,
  parameter int ONTIME_CYC = 1200000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_btn,
  input  logic estop,
  output logic motor_on
);
  localparam int MAXC = (WINDOW_CYC > ONTIME_CYC) ? WINDOW_CYC : ONTIME_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          press;
  logic          clr;
  logic          expired;
  logic [CW-1:0] limit;
  logic [CW-1:0] t_count;
  dpm_state_e    state;

  dpm_press_detect u_press (
    .clk   (clk),
    .rst   (rst),
    .level (run_btn),
    .press (press)
  );

  dpm_cycle_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .limit   (limit),
    .count   (t_count),
    .expired (expired)
  );

  dpm_fsm #(
    .WINDOW_CYC (WINDOW_CYC),
    .ONTIME_CYC (ONTIME_CYC),
    .CW         (CW)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .press    (press),
    .estop    (estop),
    .expired  (expired),
    .state    (state),
    .limit    (limit),
    .clr      (clr),
    .motor_on (motor_on)
  );

  // R8
  estop_off_chk: assert property (@(posedge clk) disable iff (rst)
    estop |=> (!motor_on && state == ST_IDLE));
  // R7
  ontime_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (t_count < CW'(ONTIME_CYC)));
  // R5
  window_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED) |-> (t_count < CW'(WINDOW_CYC)));
  // R9
  out_state_chk: assert property (@(posedge clk) disable iff (rst)
    motor_on == (state == ST_RUN));
endmodule

// File: tb/dbl_press_motor_ctrl_bench.sv
module dbl_press_motor_ctrl_bench;
  localparam int W  = 20;
  localparam int ON = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_btn = 1'b0;
  logic estop = 1'b0;
  logic motor_on;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";

  // behavioural reference
  int  m_mode = 0;
  int  m_age = 0;
  bit  m_last = 0;
  bit  m_motor = 0;

  dbl_press_motor_ctrl #(.WINDOW_CYC(W), .ONTIME_CYC(ON)) u_dbl_press_motor_ctrl (
    .clk      (clk),
    .rst      (rst),
    .run_btn  (run_btn),
    .estop    (estop),
    .motor_on (motor_on)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    bit pr;
    pr = run_btn && !m_last;
    if (rst) begin
      m_mode = 0; m_age = 0; m_last = 0;
    end else begin
      m_last = run_btn;
      if (estop) m_mode = 0;
      else if (m_mode == 0) begin
        if (pr) begin m_mode = 1; m_age = 0; end
      end else if (m_mode == 1) begin
        m_age++;
        if (m_age >= W) m_mode = 0;
        else if (pr) begin m_mode = 2; m_age = 0; end
      end else begin
        m_age++;
        if (pr || m_age >= ON) m_mode = 0;
      end
    end
    m_motor = (m_mode == 2);
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (motor_on !== m_motor) begin
        errors++;
        $display("FAIL %s model compare: motor_on=%0b expected=%0b t=%0t",
                 cur_req, motor_on, m_motor, $time);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input bit b, input bit e);
    @(negedge clk);
    run_btn = b;
    estop = e;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit exp, input string tag);
    checks++;
    if (motor_on !== exp) begin
      errors++;
      $display("FAIL %s: motor_on=%0b expected=%0b", tag, motor_on, exp);
    end
  endtask

  initial begin
    repeat (3) step(0, 0);
    rst = 1'b0;
    step(0, 0);
    chk(0, "R1 reset");

    // R3 single press only arms, then window lapses (R5)
    cur_req = "R3";
    step(1, 0); chk(0, "R3 arm");
    repeat (W + 4) step(0, 0);
    chk(0, "R5 lapse");

    // R4 double press, short gap
    cur_req = "R4";
    step(1, 0); step(0, 0); step(0, 0); step(0, 0);
    step(1, 0); chk(1, "R4 gap4");
    // R6 press while running stops
    cur_req = "R6";
    step(0, 0); chk(1, "R6 still on");
    step(1, 0); chk(0, "R6 stop");
    step(0, 0);

    // R2 held button counts once
    cur_req = "R2";
    step(1, 0);
    for (int i = 0; i < 10; i++) begin
      step(1, 0); chk(0, "R2 held");
    end
    step(0, 0);
    step(1, 0); chk(1, "R2 second");
    step(0, 0); step(1, 0); chk(0, "R6 stop2");
    step(0, 0);

    // R4 boundary j = W-1
    cur_req = "R4";
    step(1, 0);
    repeat (W - 2) step(0, 0);
    step(1, 0); chk(1, "R4 j=W-1");
    step(0, 0); step(1, 0); chk(0, "R6 stop3");
    step(0, 0);

    // R5 boundary j = W ignored, next press re-arms
    cur_req = "R5";
    step(1, 0);
    repeat (W - 1) step(0, 0);
    step(1, 0); chk(0, "R5 j=W");
    step(0, 0);
    step(1, 0); chk(0, "R5 rearm");
    step(0, 0);
    step(1, 0); chk(1, "R5 start after rearm");
    step(0, 0); step(1, 0); step(0, 0);

    // R7 auto-off after ON cycles
    cur_req = "R7";
    begin
      int hi;
      step(1, 0); step(0, 0); step(1, 0);
      hi = 0;
      while (motor_on === 1'b1 && hi < 100) begin
        hi++;
        step(0, 0);
      end
      checks++;
      if (hi != ON) begin
        errors++;
        $display("FAIL R7 on-time: got=%0d expected=%0d", hi, ON);
      end
    end
    step(0, 0);

    // R8 emergency while armed
    cur_req = "R8";
    step(1, 0); step(0, 1); chk(0, "R8 armed estop");
    step(1, 0); chk(0, "R8 press after estop arms only");
    step(0, 0);
    step(1, 0); chk(1, "R8 restart");
    // emergency while running
    step(0, 1); chk(0, "R8 run estop");
    step(0, 0);
    // emergency and press together while idle
    step(1, 1); chk(0, "R8 idle simul");
    step(0, 0);
    step(1, 0); chk(0, "R8 idle simul arms fresh");
    step(0, 0);
    // emergency and press together while armed
    step(1, 1); chk(0, "R8 armed simul");
    step(0, 0);
    step(1, 0); chk(0, "R8 arm after simul");
    step(0, 0);
    step(1, 0); chk(1, "R8 start after simul");
    step(0, 0); step(1, 0); step(0, 0);

    // R1 reset mid-run
    cur_req = "R1";
    step(1, 0); step(0, 0); step(1, 0);
    rst = 1'b1; step(0, 0); rst = 1'b0;
    chk(0, "R1 reset run");
    step(1, 0); chk(0, "R1 one press arms only");
    step(0, 0); step(0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule